// File: doc/BRIEF.md
# Overcurrent Alarm Conditioner

This block takes a raw overcurrent alarm from a pin outside the chip and turns it into signals that the rest of the design can act on. The alarm is first brought into the local clock domain through a two-stage synchroniser. It is then corrected for its programmed active level and reduced to single-cycle event strobes. Each strobe marks one change from inactive to active.

An event counter accumulates these strobes. When the count reaches a programmed threshold, the block raises a one-cycle interrupt pulse and the count starts again from zero. A threshold of zero means every event fires. A separate inactivity timer, programmed in clock cycles, clears the count when no new event arrives before it runs out. The timer then waits for the next event to start again.

In parallel, the block drives a throttle request. The request is high while the alarm is active. It stays high for a programmed number of microseconds after the alarm goes away. The microsecond timebase is a plain prescaler that divides the block clock by a fixed parameter.

Top module: `oc_alarm_conditioner`

## Requirements
- R1: With `cfg_active_low` = 1 a low level on `alarm_raw` is the active alarm. With `cfg_active_low` = 0 a high level is the active alarm.
- R2: The event count rises by exactly one for each change of the corrected alarm from inactive to active. Holding the alarm active for many cycles adds nothing more.
- R3: When an event brings the count to `cfg_threshold` (threshold 1 or more), `irq_pulse` is high for exactly one cycle. In that same cycle `event_count` returns to 0.
- R4: With `cfg_threshold` = 0, every event produces an `irq_pulse` and `event_count` stays at 0.
- R5: With `cfg_irq_en` = 0, `irq_pulse` never goes high. The count still returns to 0 when it reaches the threshold.
- R6: With `cfg_filter` = F (not 0), `event_count` is cleared F cycles after the last count update if no new event arrives in that time.
- R7: Each new event restarts the inactivity timer, so events spaced closer than F keep adding up.
- R8: With `cfg_filter` = 0, the count is never cleared by inactivity.
- R9: `throttle_req` goes high at the 4th rising edge after `alarm_raw` becomes active. After the alarm deasserts, `throttle_req` goes low at the (4 + H*US_CYCLES)th rising edge, where H is `cfg_hold_us`.
- R10: With `cfg_hold_us` = 0, `throttle_req` goes low at the 4th rising edge after `alarm_raw` deasserts.
- R11: `event_count` and `irq_pulse` react at the 4th rising edge after a change on `alarm_raw`: two synchroniser stages, one edge stage and one counter stage. They do not react at the 3rd edge.
- R12: Reset clears `event_count`, `irq_pulse` and `throttle_req`. The synchroniser is preloaded with the inactive level, so an inactive pin after reset produces no event in either polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| alarm_raw | input | 1 | Asynchronous overcurrent alarm pin |
| cfg_active_low | input | 1 | 1: alarm is active low; 0: active high |
| cfg_irq_en | input | 1 | Enables the interrupt pulse |
| cfg_threshold | input | CNT_W | Event count that fires the interrupt (0 means every event) |
| cfg_filter | input | FILT_W | Inactivity window in clock cycles (0 disables clearing) |
| cfg_hold_us | input | HOLD_W | Throttle hold time after deassertion, in microseconds |
| irq_pulse | output | 1 | One-cycle interrupt strobe |
| throttle_req | output | 1 | Throttle request |
| event_count | output | CNT_W | Current event count |

## Verification
The pulses used are short or long. Long pulses that stay active for many cycles separate edge counting from level counting. Short bursts at thresholds of 3, 0 and 2 separate the "count reached" rule, the "every event" rule and the effect of the interrupt enable on the pulse versus the count.

Event pairs spaced inside and outside the inactivity window separate a timer that restarts on each event from one that runs from the first event. A long quiet period with the window set to zero shows that clearing is then off.

Deassertions with hold times of zero and two microseconds are sampled one cycle before and at the expected drop edge. A run with the alarm polarity inverted, and the pin idle-high through reset, shows the polarity correction and the reset preload.

// File: rtl/oc_pkg.sv
package oc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ENGAGED,
    PH_DRAIN
  } hold_phase_e;

  localparam int DEF_SYNC_STAGES = 2;

endpackage

// File: rtl/oc_sync_edge.sv
module oc_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_in,
  input  logic cfg_active_low,
  output logic active_q,
  output logic ev_q
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   level;

  // Synchroniser, preloaded with the inactive pin level during reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= {SYNC_STAGES{cfg_active_low}};
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw_in};
    end
  end

  // Polarity-corrected alarm level.
  assign level = sync_q[SYNC_STAGES-1] ^ cfg_active_low;

  // Registered level and inactive-to-active strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      ev_q     <= 1'b0;
    end else begin
      active_q <= level;
      ev_q     <= level & ~active_q;
    end
  end

  // R2
  ev_single_chk: assert property (@(posedge clk) disable iff (rst)
    ev_q |=> !ev_q);

  // R2
  ev_follows_level_chk: assert property (@(posedge clk) disable iff (rst)
    ev_q |-> active_q);

endmodule

// File: rtl/oc_event_count.sv
module oc_event_count #(
  parameter int CNT_W  = 8,
  parameter int FILT_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_in,
  input  logic              cfg_irq_en,
  input  logic [CNT_W-1:0]  cfg_threshold,
  input  logic [FILT_W-1:0] cfg_filter,
  output logic              irq_q,
  output logic [CNT_W-1:0]  count_q
);

  localparam logic [CNT_W:0]    ONE_EXT  = (CNT_W+1)'(1);
  localparam logic [FILT_W-1:0] FILT_ONE = FILT_W'(1);

  logic [FILT_W-1:0] timer_q;
  logic [CNT_W:0]    count_next_ext;
  logic              hit;
  logic              filt_on;

  assign count_next_ext = {1'b0, count_q} + ONE_EXT;
  assign hit     = (cfg_threshold == '0) ||
                   (count_next_ext >= {1'b0, cfg_threshold});
  assign filt_on = (cfg_filter != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      irq_q   <= 1'b0;
      timer_q <= '0;
    end else begin
      irq_q <= 1'b0;
      if (ev_in) begin
        timer_q <= cfg_filter;
        if (hit) begin
          count_q <= '0;
          irq_q   <= cfg_irq_en;
        end else begin
          count_q <= count_next_ext[CNT_W-1:0];
        end
      end else if (!filt_on) begin
        timer_q <= '0;
      end else if (timer_q != '0) begin
        timer_q <= timer_q - FILT_ONE;
        if (timer_q == FILT_ONE) begin
          count_q <= '0;
        end
      end
    end
  end

  // R3
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (count_q == '0));

  // R3
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);

  // R4
  every_event_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_in && cfg_threshold == '0 && cfg_irq_en) |=> irq_q);

  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_irq_en |=> !irq_q);

  // R8
  no_filter_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!ev_in && !filt_on) |=> $stable(count_q));

endmodule

// File: rtl/oc_throttle_hold.sv
module oc_throttle_hold
  import oc_pkg::*;
#(
  parameter int HOLD_W    = 16,
  parameter int US_CYCLES = 250
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active_in,
  input  logic [HOLD_W-1:0] cfg_hold_us,
  output logic              throttle_q
);

  localparam int PW = $clog2(US_CYCLES + 1);
  localparam logic [PW-1:0]     PRE_FIRST = PW'(US_CYCLES);
  localparam logic [PW-1:0]     PRE_NEXT  = PW'(US_CYCLES - 1);
  localparam logic [PW-1:0]     PRE_ONE   = PW'(1);
  localparam logic [HOLD_W-1:0] US_ONE    = HOLD_W'(1);

  logic [HOLD_W-1:0] us_q, us_n;
  logic [PW-1:0]     pre_q, pre_n;
  hold_phase_e       phase_n;

  // The first microsecond after release counts one extra step, so the
  // drop lands exactly H*US_CYCLES cycles after the zero-hold drop.
  always_comb begin
    us_n  = us_q;
    pre_n = pre_q;
    if (active_in) begin
      us_n  = cfg_hold_us;
      pre_n = PRE_FIRST;
    end else if (us_q != '0) begin
      if (pre_q == '0) begin
        pre_n = PRE_NEXT;
        us_n  = us_q - US_ONE;
      end else begin
        pre_n = pre_q - PRE_ONE;
      end
    end
  end

  always_comb begin
    if (active_in)       phase_n = PH_ENGAGED;
    else if (us_n != '0) phase_n = PH_DRAIN;
    else                 phase_n = PH_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      us_q       <= '0;
      pre_q      <= '0;
      throttle_q <= 1'b0;
    end else begin
      us_q       <= us_n;
      pre_q      <= pre_n;
      throttle_q <= (phase_n != PH_IDLE);
    end
  end

  // R9
  throttle_on_chk: assert property (@(posedge clk) disable iff (rst)
    active_in |=> throttle_q);

  // R10
  zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!active_in && us_q == '0) |=> !throttle_q);

endmodule

// File: rtl/oc_alarm_conditioner.sv
module oc_alarm_conditioner #(
  parameter int CNT_W       = 8,
  parameter int FILT_W      = 24,
  parameter int HOLD_W      = 16,
  parameter int US_CYCLES   = 250,
  parameter int SYNC_STAGES = oc_pkg::DEF_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alarm_raw,
  input  logic              cfg_active_low,
  input  logic              cfg_irq_en,
  input  logic [CNT_W-1:0]  cfg_threshold,
  input  logic [FILT_W-1:0] cfg_filter,
  input  logic [HOLD_W-1:0] cfg_hold_us,
  output logic              irq_pulse,
  output logic              throttle_req,
  output logic [CNT_W-1:0]  event_count
);

  logic alarm_active;
  logic alarm_event;

  oc_sync_edge #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_sync (
    .clk            (clk),
    .rst            (rst),
    .raw_in         (alarm_raw),
    .cfg_active_low (cfg_active_low),
    .active_q       (alarm_active),
    .ev_q           (alarm_event)
  );

  oc_event_count #(
    .CNT_W  (CNT_W),
    .FILT_W (FILT_W)
  ) u_count (
    .clk           (clk),
    .rst           (rst),
    .ev_in         (alarm_event),
    .cfg_irq_en    (cfg_irq_en),
    .cfg_threshold (cfg_threshold),
    .cfg_filter    (cfg_filter),
    .irq_q         (irq_pulse),
    .count_q       (event_count)
  );

  oc_throttle_hold #(
    .HOLD_W    (HOLD_W),
    .US_CYCLES (US_CYCLES)
  ) u_hold (
    .clk         (clk),
    .rst         (rst),
    .active_in   (alarm_active),
    .cfg_hold_us (cfg_hold_us),
    .throttle_q  (throttle_req)
  );

  // R12
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!irq_pulse && !throttle_req && event_count == '0));

endmodule

// File: tb/sim_oc_alarm_conditioner.sv
`timescale 1ns/1ps
module sim_oc_alarm_conditioner;

  localparam int CNT_W  = 8;
  localparam int FILT_W = 24;
  localparam int HOLD_W = 16;
  localparam int US     = 10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              alarm_raw = 1'b0;
  logic              cfg_active_low = 1'b0;
  logic              cfg_irq_en = 1'b1;
  logic [CNT_W-1:0]  cfg_threshold = 8'd3;
  logic [FILT_W-1:0] cfg_filter = '0;
  logic [HOLD_W-1:0] cfg_hold_us = '0;
  logic              irq_pulse;
  logic              throttle_req;
  logic [CNT_W-1:0]  event_count;

  oc_alarm_conditioner #(
    .CNT_W     (CNT_W),
    .FILT_W    (FILT_W),
    .HOLD_W    (HOLD_W),
    .US_CYCLES (US)
  ) u0 (
    .clk            (clk),
    .rst            (rst),
    .alarm_raw      (alarm_raw),
    .cfg_active_low (cfg_active_low),
    .cfg_irq_en     (cfg_irq_en),
    .cfg_threshold  (cfg_threshold),
    .cfg_filter     (cfg_filter),
    .cfg_hold_us    (cfg_hold_us),
    .irq_pulse      (irq_pulse),
    .throttle_req   (throttle_req),
    .event_count    (event_count)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    checks = 0;
  int    errors = 0;
  int    irq_seen = 0;
  bit    done = 0;
  int    exp_cyc[$];
  string exp_req[$];
  bit    lvl = 0;
  int    mc = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // Driver: changes the pin and pushes any interrupt the rules predict.
  task automatic set_alarm(input bit act, input string tag, output int c);
    @(negedge clk);
    alarm_raw = act ? ~cfg_active_low : cfg_active_low;
    c = cyc;
    if (act && !lvl) begin
      if (cfg_threshold == 0 || mc + 1 >= int'(cfg_threshold)) begin
        mc = 0;
        if (cfg_irq_en) begin
          exp_cyc.push_back(c + 4);
          exp_req.push_back(tag);
        end
      end else begin
        mc++;
      end
    end
    lvl = act;
  endtask

  task automatic pulse(input string tag, input int hi, input int lo);
    int c;
    set_alarm(1'b1, tag, c);
    repeat (hi - 1) @(negedge clk);
    set_alarm(1'b0, tag, c);
    repeat (lo) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    lvl = 0;
    mc  = 0;
  endtask

  // Monitor: pops one expected interrupt per observed pulse.
  always @(negedge clk) begin
    int    e;
    string r;
    if (!rst && irq_pulse) begin
      irq_seen++;
      checks++;
      if (exp_cyc.size() == 0) begin
        errors++;
        $display("FAIL R5: actual irq at cycle %0d expected none", cyc);
      end else begin
        e = exp_cyc.pop_front();
        r = exp_req.pop_front();
        if (cyc != e) begin
          errors++;
          $display("FAIL %s: actual irq cycle %0d expected %0d", r, cyc, e);
        end
      end
    end
  end

  initial begin
    int c0, c1, c2;
    // R12 reset state
    repeat (3) @(negedge clk);
    check("R12", int'(event_count), 0);
    check("R12", int'(irq_pulse), 0);
    check("R12", int'(throttle_req), 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check("R12", int'(event_count), 0);

    // R11 latency, R9 rise, R2 one count per edge
    set_alarm(1'b1, "R2", c0);
    wait_cyc(c0 + 3);
    check("R11", int'(event_count), 0);
    check("R9", int'(throttle_req), 0);
    wait_cyc(c0 + 4);
    check("R11", int'(event_count), 1);
    check("R9", int'(throttle_req), 1);
    wait_cyc(c0 + 25);
    check("R2", int'(event_count), 1);
    // R10 zero hold
    set_alarm(1'b0, "R10", c1);
    wait_cyc(c1 + 3);
    check("R10", int'(throttle_req), 1);
    wait_cyc(c1 + 4);
    check("R10", int'(throttle_req), 0);
    check("R2", int'(event_count), 1);

    // R3 threshold 3
    pulse("R3", 3, 8);
    check("R3", int'(event_count), 2);
    pulse("R3", 3, 8);
    check("R3", int'(event_count), 0);
    check("R3", irq_seen, 1);

    // R4 threshold 0
    cfg_threshold = 8'd0;
    pulse("R4", 2, 8);
    pulse("R4", 2, 8);
    pulse("R4", 2, 8);
    check("R4", int'(event_count), 0);
    check("R4", irq_seen, 4);

    // R5 interrupts disabled, count still wraps
    cfg_irq_en = 1'b0;
    cfg_threshold = 8'd2;
    pulse("R5", 2, 8);
    check("R5", int'(event_count), 1);
    pulse("R5", 2, 8);
    check("R5", int'(event_count), 0);
    check("R5", irq_seen, 4);

    // R6 inactivity clear
    cfg_irq_en = 1'b1;
    cfg_threshold = 8'd10;
    cfg_filter = 24'd30;
    set_alarm(1'b1, "R6", c0);
    repeat (2) @(negedge clk);
    set_alarm(1'b0, "R6", c1);
    wait_cyc(c0 + 33);
    check("R6", int'(event_count), 1);
    wait_cyc(c0 + 34);
    check("R6", int'(event_count), 0);
    mc = 0;

    // R7 restart of the window by a new event
    set_alarm(1'b1, "R7", c1);
    repeat (2) @(negedge clk);
    set_alarm(1'b0, "R7", c0);
    wait_cyc(c1 + 20);
    set_alarm(1'b1, "R7", c2);
    repeat (2) @(negedge clk);
    set_alarm(1'b0, "R7", c0);
    wait_cyc(c1 + 36);
    check("R7", int'(event_count), 2);
    wait_cyc(c2 + 33);
    check("R7", int'(event_count), 2);
    wait_cyc(c2 + 34);
    check("R7", int'(event_count), 0);
    mc = 0;

    // R8 no clearing with window 0
    cfg_filter = '0;
    pulse("R8", 2, 4);
    check("R8", int'(event_count), 1);
    repeat (150) @(negedge clk);
    check("R8", int'(event_count), 1);

    // R9 hold of two microseconds
    cfg_hold_us = 16'd2;
    set_alarm(1'b1, "R9", c0);
    wait_cyc(c0 + 4);
    check("R9", int'(throttle_req), 1);
    repeat (5) @(negedge clk);
    set_alarm(1'b0, "R9", c1);
    wait_cyc(c1 + 3 + 2 * US);
    check("R9", int'(throttle_req), 1);
    wait_cyc(c1 + 4 + 2 * US);
    check("R9", int'(throttle_req), 0);

    // R1 active-low polarity, R12 preload with idle-high pin
    cfg_active_low = 1'b1;
    alarm_raw = 1'b1;
    do_reset();
    repeat (6) @(negedge clk);
    check("R12", int'(event_count), 0);
    check("R12", int'(throttle_req), 0);
    set_alarm(1'b1, "R1", c0);
    check("R1", int'(alarm_raw), 0);
    wait_cyc(c0 + 4);
    check("R1", int'(event_count), 1);
    check("R1", int'(throttle_req), 1);
    set_alarm(1'b0, "R1", c1);
    repeat (40) @(negedge clk);
    check("R1", int'(event_count), 1);
    check("R1", int'(throttle_req), 0);

    // all predicted interrupts observed
    check("R3", exp_cyc.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule